// File: doc/BRIEF.md
# Synchronous Serial Shift Port with Selectable Transfer Clock

This block moves one byte at a time over a three-wire synchronous link: a serial clock, a data input and a data output. A 16-bit mode register decides where the transfer clock comes from. A 5-bit clock-select field picks one of several divided internal clocks. In that case the port is the master and drives the serial clock. The field can instead pick the external clock. In that case the port is the slave: it takes the incoming serial clock through a synchronizer and acts on its edges in the system clock domain. Two more register bits set the shape of the clock. One sets the level the line rests at. The other sets the edge on which incoming data is sampled. Together they give four clock types.

Internal clocks come from two enable strobes, one slow and one fast. The slow source is used as it is or halved. The fast source is divided by any power of two from 1 to 128. A transfer starts with a one-cycle start strobe in idle. It shifts eight bits, most significant bit first, and ends with a one-cycle done pulse. During a transfer the mode register cannot be changed, and further start strobes have no effect.

The control sequence has three named states. SHIFT_IDLE waits for start and holds the clock at its rest level. SHIFT_RUN counts sixteen half-periods of the clock. SHIFT_END raises done for one cycle. The transitions are: idle-to-run on start, run-to-end on the sixteenth clock edge, and end-to-idle unconditionally.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the mode register reads 0x0000, the serial clock rests high and is driven (output enable 1), and busy and done are 0.
- R2: The high byte strobe writes bits 15..8 and the low byte strobe writes bits 7..0; both strobes together make a word write. Bits 15 and 7..4 always read 0 and ignore writes. Bits 3..0 read back what was written. Bit 14 is the sample-edge bit, bit 13 is the rest-level bit and bits 12..8 are the clock-select field.
- R3: A register write made while busy is 1 leaves the register unchanged.
- R4: Clock-select 00000 makes each slow enable pulse one half-period of the serial clock, and 00001 uses two slow pulses. Codes 10000 to 10111 use 2^n fast enable pulses per half-period, with n taken from bits 10..8. Every other code except 11000 behaves as 00000. The half-period count restarts at each start, so with the fast enable held high and code 10010 busy stays high for 65 cycles.
- R5: With bit 13 at 0 the serial clock rests high, and with bit 13 at 1 it rests low. It makes sixteen transitions per transfer and is back at rest when done rises.
- R6: With bit 14 at 0 the data input is sampled on rising edges; with bit 14 at 1 it is sampled on falling edges. The data output moves to the next bit on the opposite edge, but only after a bit has been sampled. Both directions are MSB first, and rx_data holds the 8 sampled bits while done is 1.
- R7: Clock-select 11000 makes the port a slave. The output enable is 0, the port does not toggle the serial clock itself, and each edge of the incoming clock acts as one half-period after it has passed a two-flop synchronizer. The external clock must stay at or below one eighth of the system clock rate.
- R8: busy is 1 from the cycle after an idle start until the end of the done cycle. done is a single-cycle pulse raised once per transfer.
- R9: A start strobe while busy is 1 has no effect on the transfer in progress or on the data shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_lo | input | 1 | Write strobe for mode register bits 7..0 |
| reg_wr_hi | input | 1 | Write strobe for mode register bits 15..8 |
| reg_wdata | input | 16 | Mode register write data |
| reg_rdata | output | 16 | Mode register read value |
| lsclk_en | input | 1 | Slow clock enable strobe |
| hsclk_en | input | 1 | Fast clock enable strobe |
| start | input | 1 | Starts a transfer when idle |
| tx_data | input | 8 | Byte to send, taken at start |
| rx_data | output | 8 | Byte received |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| sck_in | input | 1 | Incoming serial clock (slave mode) |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for sck_out |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |

## Verification
The hardest case to reach from the ports is slave mode. There, the moment a bit is sampled depends on the synchronizer delay, the phase of the external clock and the rest level, all at once. The bench drives the incoming clock slowly and symmetrically for both rest levels. It lets the clock settle at its rest level before start, and it feeds each data bit from a reference model that counts sampling edges itself. In the same run, register writes and extra start strobes are fired in the middle of a transfer, and the register read-back and the shifted-out byte are compared afterwards.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int SEL_W = 5;
    localparam int EXP_W = 3;
    localparam logic [SEL_W-1:0] SEL_SLOW      = 5'b00000;
    localparam logic [SEL_W-1:0] SEL_SLOW_HALF = 5'b00001;
    localparam logic [SEL_W-1:0] SEL_EXTERNAL  = 5'b11000;
    localparam logic [15:0]      MODE_RW_MASK  = 16'h7F0F;

    typedef enum logic [1:0] {
        SHIFT_IDLE = 2'd0,
        SHIFT_RUN  = 2'd1,
        SHIFT_END  = 2'd2
    } shift_state_e;

    typedef struct packed {
        logic             edge_inv;
        logic             rest_low;
        logic [SEL_W-1:0] sel;
    } clk_cfg_t;

    typedef struct packed {
        logic             external;
        logic             fast;
        logic [EXP_W-1:0] div_exp;
    } clk_src_t;

endpackage

// File: rtl/ssp_mode_reg.sv
module ssp_mode_reg
    import ssp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        busy,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output clk_cfg_t    cfg
);

    logic [15:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (!busy) begin
            if (wr_hi) word_q[15:8] <= wdata[15:8] & MODE_RW_MASK[15:8];
            if (wr_lo) word_q[7:0]  <= wdata[7:0]  & MODE_RW_MASK[7:0];
        end
    end

    always_comb begin
        rdata        = word_q;
        cfg.edge_inv = word_q[14];
        cfg.rest_low = word_q[13];
        cfg.sel      = word_q[12:8];
    end

    // R3: the register is frozen while a transfer runs
    a_r3_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (wr_lo || wr_hi)) |=> (word_q == $past(word_q)));

endmodule

// File: rtl/ssp_src_decode.sv
module ssp_src_decode
    import ssp_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output clk_src_t         src
);

    always_comb begin
        src = '0;
        if (sel == SEL_EXTERNAL) begin
            src.external = 1'b1;
        end else if (sel == SEL_SLOW_HALF) begin
            src.div_exp = EXP_W'(1);
        end else if (sel[SEL_W-1:SEL_W-2] == 2'b10) begin
            src.fast    = 1'b1;
            src.div_exp = sel[EXP_W-1:0];
        end
    end

endmodule

// File: rtl/ssp_clk_gen.sv
module ssp_clk_gen
    import ssp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  clk_src_t src,
    input  logic     lsclk_en,
    input  logic     hsclk_en,
    input  logic     sck_in,
    output logic     tick
);

    localparam int CNT_W = (1 << EXP_W) - 1;

    logic [SYNC_STAGES:0] sync_q;
    logic [CNT_W-1:0]     div_q;
    logic [CNT_W-1:0]     div_lim;
    logic                 src_en;
    logic                 ext_edge;
    logic                 master_tick;

    generate
        for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= sck_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_comb begin
        ext_edge    = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
        div_lim     = ~({CNT_W{1'b1}} << src.div_exp);
        src_en      = src.fast ? hsclk_en : lsclk_en;
        master_tick = run && src_en && (div_q == div_lim);
        tick        = src.external ? (run && ext_edge) : master_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run) begin
            div_q <= '0;
        end else if (src_en && !src.external) begin
            div_q <= (div_q == div_lim) ? '0 : div_q + 1'b1;
        end
    end

    // R4: the prescaler never passes the selected half-period
    a_r4_div_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (div_q <= div_lim));

endmodule

// File: rtl/ssp_shift_ctrl.sv
module ssp_shift_ctrl
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              sdi,
    input  logic              tick,
    input  logic              external,
    input  logic              edge_inv,
    input  logic              rest_low,
    output logic              run,
    output logic              busy,
    output logic              done,
    output logic              sdo,
    output logic              sck_level,
    output logic [DATA_W-1:0] rx_data
);

    localparam int HALF_N = 2 * DATA_W;
    localparam int HALF_W = $clog2(HALF_N);
    localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALF_N - 1);

    shift_state_e      state_q, state_d;
    logic [HALF_W-1:0] half_q;
    logic [DATA_W-1:0] tx_q, rx_q;
    logic              sck_q;
    logic              rest_lvl;
    logic              sample_on_lead;
    logic              capture;

    always_comb begin
        rest_lvl       = ~rest_low;
        sample_on_lead = rest_low ^ edge_inv;
        capture        = (~half_q[0]) == sample_on_lead;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SHIFT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SHIFT_IDLE: if (start) state_d = SHIFT_RUN;
            SHIFT_RUN:  if (tick && half_q == HALF_LAST) state_d = SHIFT_END;
            SHIFT_END:  state_d = SHIFT_IDLE;
            default:    state_d = SHIFT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            sck_q  <= 1'b1;
        end else begin
            unique case (state_q)
                SHIFT_IDLE: begin
                    sck_q <= rest_lvl;
                    if (start) begin
                        tx_q   <= tx_data;
                        half_q <= '0;
                    end
                end
                SHIFT_RUN: begin
                    if (tick) begin
                        half_q <= half_q + 1'b1;
                        if (!external) sck_q <= ~sck_q;
                        if (capture)
                            rx_q <= {rx_q[DATA_W-2:0], sdi};
                        else if (half_q != '0)
                            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        run       = (state_q == SHIFT_RUN);
        busy      = (state_q != SHIFT_IDLE);
        done      = (state_q == SHIFT_END);
        sck_level = run ? sck_q : rest_lvl;
        sdo       = tx_q[DATA_W-1];
        rx_data   = rx_q;
    end

    // R8: done lasts exactly one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: sixteen toggles bring the clock back to its rest level
    a_r5_rest_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SHIFT_END) |-> (sck_q == rest_lvl));

    // R4: the bit position only advances on a clock tick
    a_r4_half_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SHIFT_RUN && !tick) |=> (half_q == $past(half_q)));

    // R9: a start while busy does not restart the count
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SHIFT_RUN && start && !tick) |=> (state_q == SHIFT_RUN && half_q == $past(half_q)));

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_lo,
    input  logic              reg_wr_hi,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              lsclk_en,
    input  logic              hsclk_en,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              done,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo
);

    clk_cfg_t cfg;
    clk_src_t src;
    logic     run;
    logic     tick;

    ssp_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .wr_lo (reg_wr_lo),
        .wr_hi (reg_wr_hi),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    ssp_src_decode u_dec (
        .sel (cfg.sel),
        .src (src)
    );

    ssp_clk_gen #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .src      (src),
        .lsclk_en (lsclk_en),
        .hsclk_en (hsclk_en),
        .sck_in   (sck_in),
        .tick     (tick)
    );

    ssp_shift_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tx_data   (tx_data),
        .sdi       (sdi),
        .tick      (tick),
        .external  (src.external),
        .edge_inv  (cfg.edge_inv),
        .rest_low  (cfg.rest_low),
        .run       (run),
        .busy      (busy),
        .done      (done),
        .sdo       (sdo),
        .sck_level (sck_out),
        .rx_data   (rx_data)
    );

    assign sck_oe = ~src.external;

    // R7: in slave mode the port never drives its own clock transitions
    a_r7_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_oe && $stable(cfg)) |-> $stable(sck_out));

endmodule

// File: tb/sync_serial_port_test.sv
`timescale 1ns/1ps
module sync_serial_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_lo = 1'b0, reg_wr_hi = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        lsclk_en = 1'b0, hsclk_en = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  tx_data = '0;
    logic [7:0]  rx_data;
    logic        busy, done;
    logic        sck_in = 1'b1;
    logic        sck_out, sck_oe;
    logic        sdi = 1'b0;
    logic        sdo;

    always #4 clk = ~clk;

    sync_serial_port uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_lo(reg_wr_lo), .reg_wr_hi(reg_wr_hi),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lsclk_en(lsclk_en),
        .hsclk_en(hsclk_en), .start(start), .tx_data(tx_data), .rx_data(rx_data),
        .busy(busy), .done(done), .sck_in(sck_in), .sck_out(sck_out),
        .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo)
    );

    int n_cmp = 0, n_bad = 0;
    bit cmp_en = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // enable strobe generation
    int ls_per = 4, hs_per = 1, en_cnt = 0;
    always @(negedge clk) begin
        en_cnt++;
        lsclk_en <= (en_cnt % ls_per) == 0;
        hsclk_en <= (en_cnt % hs_per) == 0;
    end

    // behavioural reference model
    logic [15:0] m_word;
    int          m_state, m_half, m_div, m_nsamp;
    logic [7:0]  m_tx, seen_tx;
    bit          m_sck, h1, h2, h3;
    logic [7:0]  pat_q = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_word = '0; m_state = 0; m_half = 0; m_div = 0; m_nsamp = 0;
            m_tx = '0; seen_tx = '0; m_sck = 1; h1 = 0; h2 = 0; h3 = 0;
        end else begin
            int   old_st, per;
            bit   ext, fast, en, edge_seen, tick, rest, slead, lead;
            logic [4:0] sel;
            old_st = m_state;
            sel  = m_word[12:8];
            ext  = (sel == 5'b11000);
            fast = (sel[4:3] == 2'b10);
            per  = fast ? (1 << sel[2:0]) : ((sel == 5'b00001) ? 2 : 1);
            en   = fast ? hsclk_en : lsclk_en;
            edge_seen = h2 ^ h3;
            h3 = h2; h2 = h1; h1 = sck_in;
            tick = 0;
            if (m_state == 1) begin
                if (ext) tick = edge_seen;
                else if (en) begin
                    if (m_div == per - 1) begin tick = 1; m_div = 0; end
                    else m_div++;
                end
            end else m_div = 0;
            rest  = !m_word[13];
            slead = (rest == m_word[14]);  // leading edge is the sampling edge
            case (m_state)
                0: begin
                    m_sck = rest;
                    if (start) begin
                        m_tx = tx_data; m_half = 0; m_nsamp = 0; seen_tx = '0; m_state = 1;
                    end
                end
                1: if (tick) begin
                    lead = (m_half % 2) == 0;
                    if (lead == slead) begin
                        seen_tx = {seen_tx[6:0], sdo};
                        m_nsamp++;
                    end else if (m_half != 0) m_tx = {m_tx[6:0], 1'b0};
                    if (!ext) m_sck = !m_sck;
                    if (m_half == 15) m_state = 2;
                    m_half++;
                end
                default: m_state = 0;
            endcase
            if (old_st == 0) begin
                if (reg_wr_hi) m_word[15:8] = reg_wdata[15:8] & 8'h7F;
                if (reg_wr_lo) m_word[7:0]  = reg_wdata[7:0] & 8'h0F;
            end
        end
    end

    always @(negedge clk) sdi <= (m_nsamp < 8) ? pat_q[7 - m_nsamp] : 1'b0;

    int busy_cycles = 0, n_done = 0;
    always @(negedge clk) begin
        if (busy === 1'b1) busy_cycles++;
        if (done === 1'b1) n_done++;
        if (cmp_en) begin
            chk("R2 register read", reg_rdata, m_word);
            chk("R5 serial clock level", sck_out, (m_state == 1) ? m_sck : !m_word[13]);
            chk("R7 clock output enable", sck_oe, m_word[12:8] != 5'b11000);
            chk("R6 data out", sdo, m_tx[7]);
            chk("R8 busy", busy, m_state != 0);
            chk("R8 done", done, m_state == 2);
        end
    end

    task automatic wr(input bit lo, input bit hi, input logic [15:0] d);
        @(negedge clk);
        reg_wr_lo = lo; reg_wr_hi = hi; reg_wdata = d;
        @(negedge clk);
        reg_wr_lo = 0; reg_wr_hi = 0;
    endtask

    task automatic begin_xfer(input logic [7:0] txd, input logic [7:0] pat);
        @(negedge clk);
        pat_q = pat; tx_data = txd; start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic end_xfer(input logic [7:0] txd, input logic [7:0] pat, input string tag);
        for (int i = 0; i < 5000; i++) begin
            if (done === 1'b1) break;
            @(negedge clk);
        end
        chk({tag, " done seen"}, done, 1'b1);
        chk({tag, " R6 received byte"}, rx_data, pat);
        chk({tag, " R6 sent byte"}, seen_tx, txd);
        @(negedge clk);
    endtask

    task automatic slave_clock(input int toggles);
        for (int i = 0; i < toggles; i++) begin
            repeat (8) @(negedge clk);
            sck_in = ~sck_in;
        end
    endtask

    int n_xfer = 0;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reg after reset", reg_rdata, 16'h0000);
        chk("R1 clock rests high", sck_out, 1'b1);
        chk("R1 clock driven", sck_oe, 1'b1);
        chk("R1 busy", busy, 1'b0);
        chk("R1 done", done, 1'b0);
        cmp_en = 1;

        // R2 register access
        wr(1, 1, 16'hFFFF);
        chk("R2 word write", reg_rdata, 16'h7F0F);
        wr(0, 1, 16'h00FF);
        chk("R2 high byte only", reg_rdata, 16'h000F);
        wr(1, 0, 16'hFFA5);
        chk("R2 low byte reserved bits", reg_rdata, 16'h0005);

        // R4: fast clock /4, rest high, rising sample; busy length
        wr(1, 1, 16'h1200);
        hs_per = 1;
        busy_cycles = 0;
        begin_xfer(8'hA5, 8'h3C);
        end_xfer(8'hA5, 8'h3C, "R4 fast/4");
        n_xfer++;
        chk("R4 busy cycles fast/4", busy_cycles, 65);

        // R6: falling sample, fast /1 with gappy enable
        wr(1, 1, 16'h5000);
        hs_per = 2;
        begin_xfer(8'h5A, 8'hC3);
        end_xfer(8'h5A, 8'hC3, "R6 falling sample");
        n_xfer++;

        // R5: rest low, slow /2
        wr(1, 1, 16'h2100);
        chk("R5 rests low", sck_out, 1'b0);
        ls_per = 3;
        begin_xfer(8'h81, 8'h7E);
        end_xfer(8'h81, 8'h7E, "R5 rest low slow/2");
        n_xfer++;

        // R6/R4: rest low, falling sample, fast /128
        wr(1, 1, 16'h7700);
        hs_per = 1;
        begin_xfer(8'hF0, 8'h0F);
        end_xfer(8'hF0, 8'h0F, "R4 fast/128");
        n_xfer++;

        // R4: unlisted code behaves as slow clock; R3 write lock; R9 start ignored
        wr(1, 1, 16'h0A03);
        ls_per = 2;
        begin_xfer(8'h96, 8'h69);
        wr(1, 1, 16'hFFFF);
        @(negedge clk); tx_data = 8'h00; start = 1;
        @(negedge clk); start = 0;
        end_xfer(8'h96, 8'h69, "R9 start while busy");
        n_xfer++;
        chk("R3 write during transfer", reg_rdata, 16'h0A03);

        // R7: slave with rest high
        sck_in = 1;
        wr(1, 1, 16'h1800);
        chk("R7 slave output enable", sck_oe, 1'b0);
        repeat (4) @(negedge clk);
        begin_xfer(8'h3B, 8'hD2);
        slave_clock(16);
        end_xfer(8'h3B, 8'hD2, "R7 slave rest high");
        n_xfer++;

        // R7: slave with rest low, falling sample
        sck_in = 0;
        wr(1, 1, 16'h7800);
        repeat (4) @(negedge clk);
        begin_xfer(8'hE4, 8'h1B);
        slave_clock(16);
        end_xfer(8'hE4, 8'h1B, "R7 slave rest low");
        n_xfer++;

        repeat (4) @(negedge clk);
        chk("R8 done pulse count", n_done, n_xfer);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule